// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block decides, every clock cycle, which interrupt source a processor core should service next and whether that source is urgent enough to suspend the code now running. It takes a vector of requests that are already pending and enabled, three fixed system exceptions (reset, non-maskable and hard fault), a per-source priority array that it holds itself, three global masks and the priority level of the code that is currently executing. It reports a registered take request, the exception number of the winner and the winner's preemption level.

Each source owns an 8-bit priority field. Only the upper `PRIO_BITS` bits of the field are stored; the low bits always read as zero. A 3-bit group setting splits the field. The upper part is the preemption level and the lower part is the subpriority. Selection among pending sources uses the whole field. The preemption decision uses only the upper part, so two sources that differ only in subpriority cannot interrupt each other.

Top module: `irq_preempt_arbiter`

## Requirements
- R1: A priority write stores `prio_wdata` with its low `8-PRIO_BITS` bits forced to zero, and `prio_rdata` returns the stored field of source `prio_ridx`. All fields are 0 after reset, and a source with field 0 has the highest programmable priority.
- R2: Among eligible sources the numerically smallest field wins. Ties go to the lowest source number. Source n is reported as `win_num` = 16+n.
- R3: With group setting g (0..7), the reported level of a programmable winner is its field with the low g bits cleared. This level is always zero or positive.
- R4: `take_req` is 1 only when a winner exists and `win_lvl` is strictly smaller than `cur_lvl` as a signed value. An equal level never causes a take.
- R5: While `primask` is 1, no programmable source is eligible. The non-maskable exception, the hard fault and the reset exception stay eligible.
- R6: While `faultmask` is 1, no programmable source and no hard fault is eligible. The reset exception and the non-maskable exception stay eligible.
- R7: When `basepri` with its unimplemented low bits cleared is nonzero, a source whose field is at or above that value is not eligible. A value of 0 disables this threshold.
- R8: System exceptions beat every programmable source. Their order is reset (`win_num` 1, level -3), then non-maskable (2, level -2), then hard fault (3, level -1).
- R9: Outputs are registered and reflect the inputs and the stored fields of the previous rising edge. With no eligible request, or during reset, the outputs are `take_req`=0, `win_num`=0 and `win_lvl`=256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_we | input | 1 | Priority field write strobe |
| prio_widx | input | IDX_W | Source number to write |
| prio_wdata | input | 8 | Priority field write value |
| prio_ridx | input | IDX_W | Source number to read |
| prio_rdata | output | 8 | Stored field of `prio_ridx` |
| pend_en | input | NUM_IRQ | Pending-and-enabled request per source |
| sys_rst_req | input | 1 | Reset exception request |
| nmi_req | input | 1 | Non-maskable exception request |
| hfault_req | input | 1 | Hard fault request |
| primask | input | 1 | Blocks all programmable sources |
| faultmask | input | 1 | Blocks programmable sources and hard fault |
| basepri | input | 8 | Priority threshold mask, 0 = off |
| grp_sel | input | 3 | Number of low field bits used as subpriority |
| cur_lvl | input | 10 | Signed level of the code now executing (256 = none active) |
| take_req | output | 1 | Winner may preempt current execution |
| win_num | output | NUM_W | Exception number of the winner, 0 = none |
| win_lvl | output | 10 | Signed preemption level of the winner |

## Verification
The bench builds the block with eight sources and five implemented priority bits. This keeps every source inside a single hand-written scenario. It also leaves three unimplemented low bits, which makes the write masking, the masked threshold and the low group settings observable. Group settings of 4, 5 and 7 push sources with different fields into the same preemption level. That exposes the split between selection and preemption. The three system exceptions are driven together with every mask, so the fixed ordering and the mask exemptions are all reached.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int FIELD_W = 8;
  localparam int LVL_W   = 10;

  localparam logic signed [LVL_W-1:0] LVL_IDLE   = 10'sd256;
  localparam logic signed [LVL_W-1:0] LVL_RESET  = -10'sd3;
  localparam logic signed [LVL_W-1:0] LVL_NMI    = -10'sd2;
  localparam logic signed [LVL_W-1:0] LVL_HFAULT = -10'sd1;

  localparam int EXC_RESET    = 1;
  localparam int EXC_NMI      = 2;
  localparam int EXC_HFAULT   = 3;
  localparam int EXC_IRQ_BASE = 16;

  // bits of the 8-bit field that are actually stored
  function automatic logic [FIELD_W-1:0] impl_mask(input int pbits);
    logic [FIELD_W-1:0] m;
    m = 8'hFF << (FIELD_W - pbits);
    return m;
  endfunction

  // preemption part: field with the low grp bits cleared
  function automatic logic [FIELD_W-1:0] preempt_part(input logic [FIELD_W-1:0] field,
                                                      input logic [2:0] grp);
    logic [FIELD_W-1:0] m;
    m = 8'hFF << grp;
    return field & m;
  endfunction

  function automatic logic signed [LVL_W-1:0] prog_level(input logic [FIELD_W-1:0] pre);
    return $signed({2'b00, pre});
  endfunction
endpackage

// File: rtl/irq_arb_prio_regs.sv
module irq_arb_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 5,
  parameter int IDX_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [FIELD_W-1:0]         wdata,
  input  logic [IDX_W-1:0]           ridx,
  output logic [FIELD_W-1:0]         rdata,
  output logic [NUM_IRQ*FIELD_W-1:0] prio_flat
);
  localparam logic [FIELD_W-1:0] KEEP = impl_mask(PRIO_BITS);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_field
    logic [FIELD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && widx == IDX_W'(i))    q <= wdata & KEEP;
    end
    assign prio_flat[i*FIELD_W +: FIELD_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (ridx == IDX_W'(i)) rdata = prio_flat[i*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/irq_arb_elig.sv
module irq_arb_elig
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]         pend,
  input  logic [NUM_IRQ*FIELD_W-1:0] prio_flat,
  input  logic                       primask,
  input  logic                       faultmask,
  input  logic [FIELD_W-1:0]         thresh,
  output logic [NUM_IRQ-1:0]         elig
);
  logic global_block;
  assign global_block = primask | faultmask;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    logic thr_block;
    assign thr_block = (thresh != '0) && (prio_flat[i*FIELD_W +: FIELD_W] >= thresh);
    assign elig[i]   = pend[i] && !global_block && !thr_block;
  end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_IRQ-1:0]         elig,
  input  logic [NUM_IRQ*FIELD_W-1:0] prio_flat,
  output logic                       any,
  output logic [IDX_W-1:0]           idx,
  output logic [FIELD_W-1:0]         field
);
  logic [NUM_IRQ:0] hit;
  logic [FIELD_W-1:0] bf [NUM_IRQ+1];
  logic [IDX_W-1:0]   bi [NUM_IRQ+1];

  assign hit[0] = 1'b0;
  assign bf[0]  = '1;
  assign bi[0]  = '0;

  // linear chain: a later source replaces the best only if strictly smaller
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stage
    logic [FIELD_W-1:0] f;
    logic               repl;
    assign f          = prio_flat[i*FIELD_W +: FIELD_W];
    assign repl       = elig[i] && (!hit[i] || f < bf[i]);
    assign hit[i+1]   = hit[i] | elig[i];
    assign bf[i+1]    = repl ? f : bf[i];
    assign bi[i+1]    = repl ? IDX_W'(i) : bi[i];
  end

  assign any   = hit[NUM_IRQ];
  assign idx   = bi[NUM_IRQ];
  assign field = bf[NUM_IRQ];
endmodule

// File: rtl/irq_preempt_arbiter.sv
module irq_preempt_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int NUM_IRQ   = 32,
  parameter  int PRIO_BITS = 5,
  localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int NUM_W     = $clog2(NUM_IRQ + EXC_IRQ_BASE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prio_we,
  input  logic [IDX_W-1:0]        prio_widx,
  input  logic [7:0]              prio_wdata,
  input  logic [IDX_W-1:0]        prio_ridx,
  output logic [7:0]              prio_rdata,
  input  logic [NUM_IRQ-1:0]      pend_en,
  input  logic                    sys_rst_req,
  input  logic                    nmi_req,
  input  logic                    hfault_req,
  input  logic                    primask,
  input  logic                    faultmask,
  input  logic [7:0]              basepri,
  input  logic [2:0]              grp_sel,
  input  logic signed [9:0]       cur_lvl,
  output logic                    take_req,
  output logic [NUM_W-1:0]        win_num,
  output logic signed [9:0]       win_lvl
);
  localparam logic [FIELD_W-1:0] KEEP = impl_mask(PRIO_BITS);

  logic [NUM_IRQ*FIELD_W-1:0] prio_flat;
  logic [NUM_IRQ-1:0]         elig;
  // named internal events for the checker
  logic [FIELD_W-1:0]         basepri_eff;
  logic                       irq_win_any;
  logic [IDX_W-1:0]           irq_win_idx;
  logic [FIELD_W-1:0]         irq_win_field;

  assign basepri_eff = basepri & KEEP;

  irq_arb_prio_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(prio_we), .widx(prio_widx), .wdata(prio_wdata),
    .ridx(prio_ridx), .rdata(prio_rdata), .prio_flat(prio_flat)
  );

  irq_arb_elig #(.NUM_IRQ(NUM_IRQ)) u_elig (
    .pend(pend_en), .prio_flat(prio_flat), .primask(primask), .faultmask(faultmask),
    .thresh(basepri_eff), .elig(elig)
  );

  irq_arb_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .prio_flat(prio_flat), .any(irq_win_any), .idx(irq_win_idx),
    .field(irq_win_field)
  );

  logic                    nxt_have;
  logic [NUM_W-1:0]        nxt_num;
  logic signed [LVL_W-1:0] nxt_lvl;

  always_comb begin
    nxt_have = 1'b1;
    nxt_num  = '0;
    nxt_lvl  = LVL_IDLE;
    if (sys_rst_req) begin
      nxt_num = NUM_W'(EXC_RESET);
      nxt_lvl = LVL_RESET;
    end else if (nmi_req) begin
      nxt_num = NUM_W'(EXC_NMI);
      nxt_lvl = LVL_NMI;
    end else if (hfault_req && !faultmask) begin
      nxt_num = NUM_W'(EXC_HFAULT);
      nxt_lvl = LVL_HFAULT;
    end else if (irq_win_any) begin
      nxt_num = NUM_W'(EXC_IRQ_BASE) + NUM_W'(irq_win_idx);
      nxt_lvl = prog_level(preempt_part(irq_win_field, grp_sel));
    end else begin
      nxt_have = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_req <= 1'b0;
      win_num  <= '0;
      win_lvl  <= LVL_IDLE;
    end else begin
      take_req <= nxt_have && (nxt_lvl < cur_lvl);
      win_num  <= nxt_num;
      win_lvl  <= nxt_lvl;
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_W     = 6,
  parameter int PRIO_BITS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_req,
  input logic [NUM_W-1:0]  win_num,
  input logic signed [9:0] win_lvl,
  input logic signed [9:0] cur_lvl,
  input logic              primask,
  input logic              faultmask,
  input logic [7:0]        basepri_eff,
  input logic              irq_win_any,
  input logic [7:0]        irq_win_field
);
  localparam logic [7:0] LOWBITS = ~(8'hFF << (8 - PRIO_BITS));
  localparam logic [NUM_W-1:0] FIRST_IRQ = NUM_W'(16);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_win_any |-> ((irq_win_field & LOWBITS) == 8'h00)); // R1

  AST_IRQ_LEVEL_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (win_num >= FIRST_IRQ) |-> (win_lvl >= 10'sd0)); // R3

  AST_TAKE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && take_req) |-> (win_lvl < $signed($past(cur_lvl)))); // R4

  AST_PRIMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && take_req && $past(primask)) |-> (win_num < FIRST_IRQ)); // R5

  AST_FAULTMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && take_req && $past(faultmask)) |->
      (win_num == NUM_W'(1) || win_num == NUM_W'(2))); // R6

  AST_BASEPRI_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_win_any && basepri_eff != 8'h00) |-> (irq_win_field < basepri_eff)); // R7

  AST_SYS_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_num != '0 && win_num < FIRST_IRQ) |-> (win_lvl < 10'sd0)); // R8

  AST_IDLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_num == '0) |-> (!take_req && win_lvl == 10'sd256)); // R9
endmodule

bind irq_preempt_arbiter irq_arb_checker #(.NUM_W(NUM_W), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_req(take_req), .win_num(win_num), .win_lvl(win_lvl),
  .cur_lvl(cur_lvl), .primask(primask), .faultmask(faultmask), .basepri_eff(basepri_eff),
  .irq_win_any(irq_win_any), .irq_win_field(irq_win_field)
);

// File: tb/irq_preempt_arbiter_tb.sv
`timescale 1ns/1ps
module irq_preempt_arbiter_tb;
  localparam int N     = 8;
  localparam int PB    = 5;
  localparam int IDX_W = $clog2(N);
  localparam int NUM_W = $clog2(N + 16);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              prio_we = 1'b0;
  logic [IDX_W-1:0]  prio_widx = '0;
  logic [7:0]        prio_wdata = '0;
  logic [IDX_W-1:0]  prio_ridx = '0;
  logic [7:0]        prio_rdata;
  logic [N-1:0]      pend_en = '0;
  logic              sys_rst_req = 1'b0, nmi_req = 1'b0, hfault_req = 1'b0;
  logic              primask = 1'b0, faultmask = 1'b0;
  logic [7:0]        basepri = '0;
  logic [2:0]        grp_sel = '0;
  logic signed [9:0] cur_lvl = 10'sd256;
  logic              take_req;
  logic [NUM_W-1:0]  win_num;
  logic signed [9:0] win_lvl;

  irq_preempt_arbiter #(.NUM_IRQ(N), .PRIO_BITS(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .prio_we(prio_we), .prio_widx(prio_widx),
    .prio_wdata(prio_wdata), .prio_ridx(prio_ridx), .prio_rdata(prio_rdata),
    .pend_en(pend_en), .sys_rst_req(sys_rst_req), .nmi_req(nmi_req),
    .hfault_req(hfault_req), .primask(primask), .faultmask(faultmask),
    .basepri(basepri), .grp_sel(grp_sel), .cur_lvl(cur_lvl),
    .take_req(take_req), .win_num(win_num), .win_lvl(win_lvl)
  );

  typedef struct { string tag; int take; int num; int lvl; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  int bp [N];   // bench copy of stored fields

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: result of each pushed stimulus appears after the next edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, int'(take_req), e.take, "take_req");
      check(e.tag, int'(win_num), e.num, "win_num");
      check(e.tag, int'(win_lvl), e.lvl, "win_lvl");
    end
  end

  function automatic exp_t model(input string tag, input logic [N-1:0] p, input bit r, input bit n,
                                 input bit h, input bit pm, input bit fm, input logic [7:0] bpri,
                                 input int g, input int cur);
    exp_t e;
    int thr, best;
    e.tag = tag; e.num = 0; e.lvl = 256;
    thr = int'({bpri[7:3], 3'b000});
    if (r)            begin e.num = 1; e.lvl = -3; end
    else if (n)       begin e.num = 2; e.lvl = -2; end
    else if (h && !fm) begin e.num = 3; e.lvl = -1; end
    else begin
      best = -1;
      for (int i = N - 1; i >= 0; i--)
        if (p[i] && !pm && !fm && !(thr != 0 && bp[i] >= thr) && (best < 0 || bp[i] <= bp[best]))
          best = i;
      if (best >= 0) begin
        e.num = 16 + best;
        e.lvl = bp[best] - (bp[best] % (1 << g));
      end
    end
    e.take = (e.num != 0 && e.lvl < cur) ? 1 : 0;
    return e;
  endfunction

  task automatic drive(input string tag, input logic [N-1:0] p, input bit r, input bit n,
                       input bit h, input bit pm, input bit fm, input logic [7:0] bpri,
                       input int g, input int cur);
    @(negedge clk);
    pend_en = p; sys_rst_req = r; nmi_req = n; hfault_req = h;
    primask = pm; faultmask = fm; basepri = bpri; grp_sel = 3'(g); cur_lvl = 10'(cur);
    q.push_back(model(tag, p, r, n, h, pm, fm, bpri, g, cur));
  endtask

  task automatic wr(input int idx, input logic [7:0] val);
    @(negedge clk);
    pend_en = '0; sys_rst_req = 0; nmi_req = 0; hfault_req = 0;
    prio_we = 1'b1; prio_widx = IDX_W'(idx); prio_wdata = val;
    @(negedge clk);
    prio_we = 1'b0;
    prio_ridx = IDX_W'(idx);
    #1;
    bp[idx] = int'({val[7:3], 3'b000});
    check("R1", int'(prio_rdata), bp[idx], "prio_rdata");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) bp[i] = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", int'(take_req), 0, "take_req at reset");
    check("R9", int'(win_num), 0, "win_num at reset");
    check("R9", int'(win_lvl), 256, "win_lvl at reset");
    prio_ridx = IDX_W'(5); #1;
    check("R1", int'(prio_rdata), 0, "field after reset");
    rst_n = 1'b1;

    // R1: low bits of writes dropped
    wr(0, 8'h40); wr(1, 8'h07); wr(2, 8'h48); wr(3, 8'hFF);
    wr(4, 8'h43); wr(5, 8'h20); wr(6, 8'h2C); wr(7, 8'h80);

    // R2: selection and numbering
    drive("R2", 8'h01, 0,0,0, 0,0, 8'h00, 0, 256);
    drive("R2", 8'h11, 0,0,0, 0,0, 8'h00, 0, 256);
    drive("R2", 8'h60, 0,0,0, 0,0, 8'h00, 0, 256);
    drive("R2", 8'hFD, 0,0,0, 0,0, 8'h00, 0, 256);
    drive("R1", 8'h02, 0,0,0, 0,0, 8'h00, 0, 0);
    drive("R1", 8'h02, 0,0,0, 0,0, 8'h00, 0, 1);
    // R3: group splits
    drive("R3", 8'h40, 0,0,0, 0,0, 8'h00, 5, 256);
    drive("R3", 8'h08, 0,0,0, 0,0, 8'h00, 7, 256);
    drive("R3", 8'h80, 0,0,0, 0,0, 8'h00, 7, 256);
    drive("R3", 8'h60, 0,0,0, 0,0, 8'h00, 4, 256);
    // R4: strict preemption on the preempt part only
    drive("R4", 8'h40, 0,0,0, 0,0, 8'h00, 4, 32);
    drive("R4", 8'h40, 0,0,0, 0,0, 8'h00, 4, 33);
    drive("R4", 8'h01, 0,0,0, 0,0, 8'h00, 0, 64);
    drive("R4", 8'h01, 0,0,0, 0,0, 8'h00, 0, 65);
    // R5: primask
    drive("R5", 8'hFF, 0,0,0, 1,0, 8'h00, 0, 256);
    drive("R5", 8'hFF, 0,0,1, 1,0, 8'h00, 0, 256);
    drive("R5", 8'hFF, 0,1,0, 1,0, 8'h00, 0, 256);
    // R6: faultmask
    drive("R6", 8'hFF, 0,0,1, 0,1, 8'h00, 0, 256);
    drive("R6", 8'hFF, 0,1,1, 0,1, 8'h00, 0, 256);
    drive("R6", 8'h00, 1,0,1, 0,1, 8'h00, 0, 256);
    // R7: threshold
    drive("R7", 8'h81, 0,0,0, 0,0, 8'h40, 0, 256);
    drive("R7", 8'hA1, 0,0,0, 0,0, 8'h40, 0, 256);
    drive("R7", 8'h81, 0,0,0, 0,0, 8'h47, 0, 256);
    drive("R7", 8'h81, 0,0,0, 0,0, 8'h07, 0, 256);
    drive("R7", 8'h08, 0,0,0, 0,0, 8'h28, 0, 256);
    // R8: system exceptions
    drive("R8", 8'hFF, 1,1,1, 0,0, 8'h00, 0, 256);
    drive("R8", 8'hFF, 1,0,0, 0,0, 8'h00, 0, -3);
    drive("R8", 8'hFF, 0,1,1, 0,0, 8'h00, 0, 256);
    drive("R8", 8'h02, 0,0,1, 0,0, 8'h00, 0, -1);
    drive("R8", 8'h02, 0,0,1, 0,0, 8'h00, 0, 0);
    // R9: idle after activity
    drive("R9", 8'h00, 0,0,0, 0,0, 8'h00, 0, 256);
    @(negedge clk);
    pend_en = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule